// File: doc/BRIEF.md
# Prioritized Interrupt Latch Controller

This block gathers interrupt requests from core events and external pins and records each in its own bit of a latch register. A software mask selects which latched requests may reach the core. The controller then presents the highest-priority eligible request as a vector index plus a request line. Two bits are always enabled: the emulator request and the reset request. The reserved position never holds a request.

When the core takes the offered request, it raises `ack`. The latch bit for that request is cleared and the same position is set in a nesting register. While that nesting bit is set, the served source and every source of lower priority are held off. Higher-priority sources can still preempt. A return-from-interrupt strobe releases the innermost level, which is the lowest-indexed set bit of the nesting register.

Three external pins each pass through a synchronizer. A per-pin mode input picks between latching on a rising transition and latching for as long as the pin is held high.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the latch register and the nesting register are all zero, `irq_req` is 0 and `irq_vec` is 0.
- R2: A one-cycle event sets its latch bit at the next clock edge. The mapping is: emulator to bit 0, either reset request (pin or software) to bit 1, stack-full to bit 3, breakpoint to bit 6.
- R3: Bit 2 is set when either the illegal-access flag or the unaligned-access flag is high. Bit 5 is set by any one of FIFO underflow, FIFO overflow or frame-sync error.
- R4: A single `timer_zero` pulse sets both bit 4 (high-priority timer) and bit 11 (low-priority timer) at the same clock edge.
- R5: `ext_irq[0]`, `ext_irq[1]` and `ext_irq[2]` feed bits 10, 9 and 8. A pin's effect reaches the latch at the third clock edge after it changes.
  - In edge mode (`ext_edge_mode[k]`=1), one rising transition sets the bit once. Holding the pin high does not set the bit again after software clears it.
  - In level mode, the bit is set on every cycle the synchronized pin is high.
- R6: A latched bit whose mask bit is 0 is not requested. Bits 0 and 1 are requested whatever the mask holds.
- R7: Among latched, enabled and unblocked bits, the lowest index wins. `irq_vec` carries that bit index in binary.
- R8: A latch write loads every bit from the written data, except that bits 0 and 1 keep their value and bit 7 always reads 0. An event on the same edge as the write still sets its bit.
- R9: With `irq_req` high, `ack` at a clock edge clears the latch bit at `irq_vec` and sets the nesting bit at that index.
- R10: While nesting bit n is set, sources with index n or above are not requested. An `rti` clears only the lowest-indexed set nesting bit.
- R11: `irq_req` is 1 exactly when some bit is eligible, and `irq_vec` is 0 when `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emu_evt | input | 1 | Emulator event |
| rst_pin_req | input | 1 | Reset request from the external pin |
| sw_rst_req | input | 1 | Software reset request |
| io_acc_err | input | 1 | Sticky illegal register-access flag |
| unaligned_err | input | 1 | Sticky unaligned 64-bit access flag |
| stack_full | input | 1 | Sequencer stack overflow or full |
| timer_zero | input | 1 | Timer reached zero |
| fifo_unf | input | 1 | Serial-port FIFO underflow |
| fifo_ovf | input | 1 | Serial-port FIFO overflow |
| fsync_err | input | 1 | Serial-port frame-sync error |
| brk_evt | input | 1 | Hardware breakpoint event |
| ext_irq | input | 3 | External request pins, index k = pin k |
| ext_edge_mode | input | 3 | Per-pin mode: 1 edge, 0 level |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 12 | Mask write data |
| latch_wr_en | input | 1 | Latch register write strobe |
| latch_wr_data | input | 12 | Latch write data |
| ack | input | 1 | Core takes the offered request |
| rti | input | 1 | Return from interrupt |
| latch_q | output | 12 | Latch register |
| nest_q | output | 12 | Nesting register |
| irq_req | output | 1 | A request is offered |
| irq_vec | output | 4 | Index of the offered request |

## Verification
The hardest state to reach from the ports is a two-deep nest in which a higher-priority source preempts a served one. To get there, the bench first acknowledges a mid-priority request and checks that lower ones are held off. It then fires the emulator event, acknowledges it too, and releases the levels one `rti` at a time, checking after each that the right nesting bit drops and the held-off request reappears. The bench also drives a level pin while a latch write clears its bit on the same edge, to confirm that a new set wins over the write.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int NSRC  = 12;
  localparam int VEC_W = 4;
  localparam int N_EXT = 3;

  localparam int B_EMU  = 0;
  localparam int B_RST  = 1;
  localparam int B_ILL  = 2;
  localparam int B_STK  = 3;
  localparam int B_TMH  = 4;
  localparam int B_SPE  = 5;
  localparam int B_BRK  = 6;
  localparam int B_RSV  = 7;
  localparam int B_EXT2 = 8;
  localparam int B_EXT0 = 10;
  localparam int B_TML  = 11;

  localparam logic [NSRC-1:0] ALWAYS_EN = NSRC'((1 << B_EMU) | (1 << B_RST));
  localparam logic [NSRC-1:0] RSV_BIT   = NSRC'(1 << B_RSV);
  localparam logic [NSRC-1:0] SW_WR     = ~(ALWAYS_EN | RSV_BIT);

  // index of the lowest set bit, 0 when none
  function automatic logic [VEC_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = VEC_W'(i);
    end
    return r;
  endfunction

  function automatic logic [NSRC-1:0] first_onehot(input logic [NSRC-1:0] v);
    return v & (~v + NSRC'(1));
  endfunction

  // bit i set when any nesting bit at index i or below is set
  function automatic logic [NSRC-1:0] held_off(input logic [NSRC-1:0] nest);
    logic [NSRC-1:0] r;
    logic            acc;
    acc = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      acc  = acc | nest[i];
      r[i] = acc;
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_pin_cap.sv
module irq_pin_cap #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_mode,
  output logic set_o
);
  logic [STAGES:0] sh;
  logic            synced;
  logic            prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign synced = sh[STAGES-1];
  assign prev   = sh[STAGES];
  assign set_o  = edge_mode ? (synced & ~prev) : synced;

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && set_o) ##1 edge_mode |-> !set_o); // R5
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_latch_pkg::*;
(
  input  logic [NSRC-1:0]  latch,
  input  logic [NSRC-1:0]  mask_eff,
  input  logic [NSRC-1:0]  nest,
  output logic [NSRC-1:0]  blocked,
  output logic [NSRC-1:0]  eligible,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  assign blocked  = held_off(nest);
  assign eligible = latch & mask_eff & ~blocked & ~RSV_BIT;
  assign req      = |eligible;
  assign vec      = first_set(eligible);
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emu_evt,
  input  logic             rst_pin_req,
  input  logic             sw_rst_req,
  input  logic             io_acc_err,
  input  logic             unaligned_err,
  input  logic             stack_full,
  input  logic             timer_zero,
  input  logic             fifo_unf,
  input  logic             fifo_ovf,
  input  logic             fsync_err,
  input  logic             brk_evt,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_edge_mode,
  input  logic             mask_wr_en,
  input  logic [NSRC-1:0]  mask_wr_data,
  input  logic             latch_wr_en,
  input  logic [NSRC-1:0]  latch_wr_data,
  input  logic             ack,
  input  logic             rti,
  output logic [NSRC-1:0]  latch_q,
  output logic [NSRC-1:0]  nest_q,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  mask_eff;
  logic [N_EXT-1:0] ext_set;
  logic [NSRC-1:0]  src_set;
  logic [NSRC-1:0]  blocked;
  logic [NSRC-1:0]  eligible;
  logic             ack_hit;
  logic [NSRC-1:0]  ack_onehot;
  logic [NSRC-1:0]  rti_onehot;
  logic [NSRC-1:0]  latch_d;
  logic [NSRC-1:0]  nest_d;

  for (genvar k = 0; k < N_EXT; k++) begin : g_pin
    irq_pin_cap #(.STAGES(SYNC_STAGES)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (ext_irq[k]),
      .edge_mode (ext_edge_mode[k]),
      .set_o     (ext_set[k])
    );
  end

  always_comb begin
    src_set        = '0;
    src_set[B_EMU] = emu_evt;
    src_set[B_RST] = rst_pin_req | sw_rst_req;
    src_set[B_ILL] = io_acc_err | unaligned_err;
    src_set[B_STK] = stack_full;
    src_set[B_TMH] = timer_zero;
    src_set[B_SPE] = fifo_unf | fifo_ovf | fsync_err;
    src_set[B_BRK] = brk_evt;
    src_set[B_TML] = timer_zero;
    for (int k = 0; k < N_EXT; k++) src_set[B_EXT0 - k] = ext_set[k];
  end

  assign mask_eff = (mask_q | ALWAYS_EN) & ~RSV_BIT;

  irq_prio_pick u_pick (
    .latch    (latch_q),
    .mask_eff (mask_eff),
    .nest     (nest_q),
    .blocked  (blocked),
    .eligible (eligible),
    .req      (irq_req),
    .vec      (irq_vec)
  );

  assign ack_hit    = ack & irq_req;
  assign ack_onehot = ack_hit ? (NSRC'(1) << irq_vec) : '0;
  assign rti_onehot = rti ? first_onehot(nest_q) : '0;

  always_comb begin
    latch_d = latch_q;
    if (latch_wr_en) latch_d = (latch_q & ~SW_WR) | (latch_wr_data & SW_WR);
    latch_d = ((latch_d & ~ack_onehot) | src_set) & ~RSV_BIT;
  end

  assign nest_d = (nest_q & ~rti_onehot) | ack_onehot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      nest_q  <= '0;
      mask_q  <= '0;
    end else begin
      latch_q <= latch_d;
      nest_q  <= nest_d;
      if (mask_wr_en) mask_q <= mask_wr_data;
    end
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q[B_RSV]); // R8
  AST_WIN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> latch_q[irq_vec] && mask_eff[irq_vec]); // R7
  AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((latch_q & mask_eff & ~blocked) & ((NSRC'(1) << irq_vec) - NSRC'(1))) == '0); // R7
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == '0); // R11
  AST_ACK_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq_req |=> nest_q[$past(irq_vec)]); // R9
  AST_TIMER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    timer_zero |=> latch_q[B_TMH] && latch_q[B_TML]); // R4
  AST_EMU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q[B_EMU] && nest_q == '0 |-> irq_req && irq_vec == VEC_W'(B_EMU)); // R6
  AST_RTI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rti && !ack && nest_q != '0 |=> $countones(nest_q) + 1 == $countones($past(nest_q))); // R10
  AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    nest_q != '0 && irq_req |-> irq_vec < first_set(nest_q)); // R10
endmodule

// File: tb/irq_latch_ctrl_bench.sv
module irq_latch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        emu_evt = 0, rst_pin_req = 0, sw_rst_req = 0, io_acc_err = 0;
  logic        unaligned_err = 0, stack_full = 0, timer_zero = 0, fifo_unf = 0;
  logic        fifo_ovf = 0, fsync_err = 0, brk_evt = 0;
  logic [2:0]  ext_irq = '0, ext_edge_mode = '0;
  logic        mask_wr_en = 0, latch_wr_en = 0, ack = 0, rti = 0;
  logic [11:0] mask_wr_data = '0, latch_wr_data = '0;
  logic [11:0] latch_q, nest_q;
  logic        irq_req;
  logic [3:0]  irq_vec;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_latch_ctrl u_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .emu_evt(emu_evt), .rst_pin_req(rst_pin_req),
    .sw_rst_req(sw_rst_req), .io_acc_err(io_acc_err), .unaligned_err(unaligned_err),
    .stack_full(stack_full), .timer_zero(timer_zero), .fifo_unf(fifo_unf),
    .fifo_ovf(fifo_ovf), .fsync_err(fsync_err), .brk_evt(brk_evt),
    .ext_irq(ext_irq), .ext_edge_mode(ext_edge_mode), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .latch_wr_en(latch_wr_en),
    .latch_wr_data(latch_wr_data), .ack(ack), .rti(rti), .latch_q(latch_q),
    .nest_q(nest_q), .irq_req(irq_req), .irq_vec(irq_vec));

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
  endtask

  task automatic wr_mask(input logic [11:0] v);
    mask_wr_en = 1; mask_wr_data = v; step(); mask_wr_en = 0;
  endtask

  task automatic wr_latch(input logic [11:0] v);
    latch_wr_en = 1; latch_wr_data = v; step(); latch_wr_en = 0;
  endtask

  task automatic do_ack();  ack = 1; step(); ack = 0; endtask
  task automatic do_rti();  rti = 1; step(); rti = 0; endtask

  task automatic t_reset();
    do_reset();
    chk("R1 latch", latch_q, 0);
    chk("R1 nest", nest_q, 0);
    chk("R1 req", irq_req, 0);
    chk("R1 vec", irq_vec, 0);
  endtask

  task automatic t_direct();
    do_reset();
    stack_full = 1; step(); stack_full = 0;
    chk("R2 stack bit3", latch_q, 12'h008);
    brk_evt = 1; step(); brk_evt = 0;
    chk("R2 brk bit6", latch_q, 12'h048);
    do_reset();
    rst_pin_req = 1; step(); rst_pin_req = 0;
    chk("R2 reset pin bit1", latch_q, 12'h002);
    do_reset();
    sw_rst_req = 1; step(); sw_rst_req = 0;
    chk("R2 sw reset bit1", latch_q, 12'h002);
    do_reset();
    emu_evt = 1; step(); emu_evt = 0;
    chk("R2 emu bit0", latch_q, 12'h001);
  endtask

  task automatic t_or_sources();
    do_reset();
    io_acc_err = 1; step(); io_acc_err = 0;
    chk("R3 illegal access", latch_q, 12'h004);
    wr_latch(0);
    unaligned_err = 1; step(); unaligned_err = 0;
    chk("R3 unaligned", latch_q, 12'h004);
    wr_latch(0);
    fifo_ovf = 1; step(); fifo_ovf = 0;
    chk("R3 fifo ovf", latch_q, 12'h020);
    wr_latch(0);
    fsync_err = 1; step(); fsync_err = 0;
    chk("R3 fsync", latch_q, 12'h020);
    wr_latch(0);
    fifo_unf = 1; step(); fifo_unf = 0;
    chk("R3 fifo unf", latch_q, 12'h020);
  endtask

  task automatic t_timer();
    do_reset();
    timer_zero = 1; step(); timer_zero = 0;
    chk("R4 both timer bits", latch_q, 12'h810);
  endtask

  task automatic t_pins();
    do_reset();
    ext_edge_mode = 3'b001;
    ext_irq[0] = 1; step(2);
    chk("R5 edge not yet", latch_q[10], 0);
    step();
    chk("R5 edge latched third edge", latch_q, 12'h400);
    wr_latch(0);
    step(3);
    chk("R5 edge held no relatch", latch_q, 0);
    ext_irq[0] = 0;
    ext_irq[1] = 1; step(3);
    chk("R5 level latched", latch_q, 12'h200);
    wr_latch(0);
    chk("R5 level wins over write R8", latch_q, 12'h200);
    ext_irq[1] = 0; step(4);
    wr_latch(0);
    chk("R5 level released", latch_q, 0);
    ext_edge_mode = 3'b100;
    ext_irq[2] = 1; step(3); ext_irq[2] = 0;
    chk("R5 pin2 bit8", latch_q, 12'h100);
  endtask

  task automatic t_mask();
    do_reset();
    brk_evt = 1; step(); brk_evt = 0;
    chk("R6 masked no req", irq_req, 0);
    chk("R11 idle vec", irq_vec, 0);
    wr_mask(12'h040);
    chk("R6 enabled req", irq_req, 1);
    chk("R6 enabled vec", irq_vec, 6);
    do_reset();
    wr_mask(0);
    rst_pin_req = 1; step(); rst_pin_req = 0;
    chk("R6 reset unmaskable", {irq_req, irq_vec}, {1'b1, 4'd1});
  endtask

  task automatic t_prio();
    do_reset();
    wr_mask(12'hFFF);
    brk_evt = 1; stack_full = 1; step(); brk_evt = 0; stack_full = 0;
    chk("R7 lowest wins", irq_vec, 3);
    wr_latch(12'h040);
    chk("R7 next wins", irq_vec, 6);
    do_reset();
    wr_mask(12'h800);
    timer_zero = 1; step(); timer_zero = 0;
    chk("R7 low timer vec11", {irq_req, irq_vec}, {1'b1, 4'd11});
  endtask

  task automatic t_write();
    do_reset();
    emu_evt = 1; step(); emu_evt = 0;
    wr_latch(12'hFFF);
    chk("R8 write ones", latch_q, 12'hF7D);
    wr_latch(12'h000);
    chk("R8 write zeros keep bit0", latch_q, 12'h001);
  endtask

  task automatic t_nest();
    do_reset();
    wr_mask(12'hFFF);
    brk_evt = 1; stack_full = 1; step(); brk_evt = 0; stack_full = 0;
    do_ack();
    chk("R9 latch cleared", latch_q, 12'h040);
    chk("R9 nest set", nest_q, 12'h008);
    chk("R10 lower held off", irq_req, 0);
    emu_evt = 1; step(); emu_evt = 0;
    chk("R10 higher preempts", {irq_req, irq_vec}, {1'b1, 4'd0});
    do_ack();
    chk("R9 nest two deep", nest_q, 12'h009);
    do_rti();
    chk("R10 rti inner", nest_q, 12'h008);
    chk("R10 still held", irq_req, 0);
    do_rti();
    chk("R10 rti outer", nest_q, 12'h000);
    chk("R10 request back", {irq_req, irq_vec}, {1'b1, 4'd6});
  endtask

  initial begin
    t_reset();
    t_direct();
    t_or_sources();
    t_timer();
    t_pins();
    t_mask();
    t_prio();
    t_write();
    t_nest();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule